// File: doc/BRIEF.md
# Cache flash-invalidate controller

This block keeps the per-block valid bits and the tree pseudo-LRU replacement state for a set-associative instruction cache and a data cache, and runs a flash-invalidate of either cache on software command. Software writes a control word that holds one invalidate command bit for each cache. When the matching cache enable input is high, the bit clears on the next clock and a sweep starts. The sweep clears one set per clock, so all blocks become invalid and every set's replacement state points at way 0. Dirty blocks are dropped and are not written back. While a sweep runs, core requests to that cache are stalled and snoop lookups to it report a miss.

Tag storage lives outside the block. For each request the core presents a set index and a per-way tag-compare vector from its tag array. The block combines that vector with its valid bits to give hit or miss and the hit way. The core request port is valid/ready. `x_req_ready` is low for the whole sweep, and a request counts only in a cycle where valid and ready are both high. The response (`x_rsp_hit`, `x_rsp_way`) is combinational in the accepted cycle and cannot be back-pressured. The line-fill port is valid/ready with the same stall rule, and it reports the replacement victim for the presented set. The snoop port is plain and never stalls. The two caches have separate sequencers, so their sweeps can overlap.

Top module: `flash_inval_top`

## Requirements
- R1: A write on the control interface loads both command bits. Write data bit 11 (bit 20 counting from the MSB of the 32-bit word) is the instruction-cache command. Bit 10 (bit 21 from the MSB) is the data-cache command. No other data bit affects either command. `cmd_pending[1]` shows the instruction command and `cmd_pending[0]` shows the data command. Both reset to 0.
- R2: With the cache enable high and no sweep running, a set command bit reads 0 on the cycle after it was set. The busy flag of that cache (`busy[1]` for instruction, `busy[0]` for data) is high in that same cycle and stays high for exactly SETS consecutive cycles.
- R3: With the cache enable low, a set command bit stays set, no sweep starts and valid state is kept. Once the enable goes high, the sweep starts on the next clock edge.
- R4: After a sweep, every block of every set in that cache is invalid, so every lookup misses.
- R5: After a sweep, and after reset, the victim way reported for any set is way 0.
- R6: While a cache is busy, its `x_req_ready` and `x_fill_ready` are low, and it reports no core hit.
- R7: While a cache is busy, its snoop port reports a miss, even for a set whose valid block matches.
- R8: When not busy, a request or snoop hits only when the tag-compare bit and the valid bit of the same way are both set. `x_rsp_way` gives the lowest such way.
- R9: Each accepted fill or hit moves the tree pseudo-LRU state to point away from the accessed way. With 4 ways, filling the reported victim each time from the all-zero state gives victims 0, 2, 1, 3 and then 0. A hit on way 2 followed by a hit on way 0 from that state gives victim 0 and then victim 3.
- R10: The instruction and data caches are independent. A sweep of one cache leaves the other cache's busy flag, ready and hits unchanged, and both sweeps can start on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 32 | Control word write data |
| ic_enable | input | 1 | Instruction cache enable |
| dc_enable | input | 1 | Data cache enable |
| cmd_pending | output | 2 | Command bits: [1] instruction, [0] data |
| busy | output | 2 | Sweep in progress: [1] instruction, [0] data |
| i_req_valid | input | 1 | Instruction core request valid |
| i_req_ready | output | 1 | Instruction core request ready |
| i_req_set | input | SET_W | Instruction request set index |
| i_req_match | input | WAYS | Instruction per-way tag compare |
| i_rsp_hit | output | 1 | Instruction request hit |
| i_rsp_way | output | WAY_W | Instruction hit way |
| i_fill_valid | input | 1 | Instruction fill valid |
| i_fill_ready | output | 1 | Instruction fill ready |
| i_fill_set | input | SET_W | Instruction fill set |
| i_fill_way | input | WAY_W | Instruction fill way |
| i_fill_victim | output | WAY_W | Instruction victim way for fill set |
| i_snp_set | input | SET_W | Instruction snoop set |
| i_snp_match | input | WAYS | Instruction snoop per-way tag compare |
| i_snp_hit | output | 1 | Instruction snoop hit |
| d_req_valid | input | 1 | Data core request valid |
| d_req_ready | output | 1 | Data core request ready |
| d_req_set | input | SET_W | Data request set index |
| d_req_match | input | WAYS | Data per-way tag compare |
| d_rsp_hit | output | 1 | Data request hit |
| d_rsp_way | output | WAY_W | Data hit way |
| d_fill_valid | input | 1 | Data fill valid |
| d_fill_ready | output | 1 | Data fill ready |
| d_fill_set | input | SET_W | Data fill set |
| d_fill_way | input | WAY_W | Data fill way |
| d_fill_victim | output | WAY_W | Data victim way for fill set |
| d_snp_set | input | SET_W | Data snoop set |
| d_snp_match | input | WAYS | Data snoop per-way tag compare |
| d_snp_hit | output | 1 | Data snoop hit |

## Verification
A valid bit that survives a sweep shows up on the first lookup after busy falls, as a hit where a miss is expected. A sweep that skips sets shows up the same way. A replacement tree that is not cleared shows at once on the victim port, as a nonzero way for a fresh set. A wrong update shows on the next fill, which breaks the 0, 2, 1, 3 victim order. Sequencer faults are visible within a cycle or two of the write: a command bit that fails to clear or stay set, a busy window of the wrong length, or a snoop that hits during the window.

// File: rtl/flinv_pkg.sv
package flinv_pkg;
  localparam int REG_W = 32;
  localparam int ICMD_BIT = REG_W - 1 - 20;
  localparam int DCMD_BIT = REG_W - 1 - 21;
  typedef enum logic {
    CACHE_D = 1'b0,
    CACHE_I = 1'b1
  } cache_sel_e;
endpackage

// File: rtl/plru_victim.sv
module plru_victim #(
  parameter int WAYS = 4,
  localparam int LVL = $clog2(WAYS),
  localparam int NB = WAYS - 1
) (
  input  logic [NB-1:0]  tree_bits,
  output logic [LVL-1:0] victim
);
  logic [WAYS-1:0] way_sel;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LVL-1:0] step_ok;
    for (genvar l = 0; l < LVL; l++) begin : g_lvl
      localparam int NODE = (1 << l) - 1 + (w >> (LVL - l));
      localparam int DIR = (w >> (LVL - 1 - l)) & 1;
      assign step_ok[l] = (tree_bits[NODE] == 1'(DIR));
    end
    assign way_sel[w] = &step_ok;
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_sel[w]) victim = LVL'(w);
    end
  end
endmodule

// File: rtl/plru_update.sv
module plru_update #(
  parameter int WAYS = 4,
  localparam int LVL = $clog2(WAYS),
  localparam int NB = WAYS - 1
) (
  input  logic [NB-1:0]  cur_bits,
  input  logic [LVL-1:0] acc_way,
  output logic [NB-1:0]  next_bits
);
  for (genvar k = 0; k < NB; k++) begin : g_node
    localparam int NLVL = $clog2(k + 2) - 1;
    localparam int POS = k - ((1 << NLVL) - 1);
    localparam int SH = LVL - NLVL;
    logic on_path;
    assign on_path = ((acc_way >> SH) == LVL'(POS));
    assign next_bits[k] = on_path ? ~acc_way[LVL-1-NLVL] : cur_bits[k];
  end
endmodule

// File: rtl/flinv_seq.sv
module flinv_seq #(
  parameter int SETS = 64,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic             enable,
  output logic             cmd_q,
  output logic             busy_q,
  output logic [SET_W-1:0] set_idx
);
  localparam logic [SET_W-1:0] LAST = SET_W'(SETS - 1);
  logic start;

  assign start = cmd_q && enable && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= 1'b0;
      busy_q  <= 1'b0;
      set_idx <= '0;
    end else begin
      if (wr_en) cmd_q <= wr_bit;
      else if (start) cmd_q <= 1'b0;
      if (start) begin
        busy_q  <= 1'b1;
        set_idx <= '0;
      end else if (busy_q) begin
        if (set_idx == LAST) begin
          busy_q  <= 1'b0;
          set_idx <= '0;
        end else begin
          set_idx <= set_idx + 1'b1;
        end
      end
    end
  end

  logic [SET_W:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else if (busy_q) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  assert_autoclear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q && enable && !busy_q && !wr_en) |=> (!cmd_q && busy_q));

  assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q && !enable && !busy_q && !wr_en) |=> (cmd_q && !busy_q));

  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (run_len == (SET_W+1)'(SETS)));
endmodule

// File: rtl/cache_state_bank.sv
module cache_state_bank #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NB = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_busy,
  input  logic [SET_W-1:0] clr_set,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SET_W-1:0] req_set,
  input  logic [WAYS-1:0]  req_match,
  output logic             rsp_hit,
  output logic [WAY_W-1:0] rsp_way,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  output logic [WAY_W-1:0] fill_victim,
  input  logic [SET_W-1:0] snp_set,
  input  logic [WAYS-1:0]  snp_match,
  output logic             snp_hit
);
  logic [WAYS-1:0] valid_q [SETS];
  logic [NB-1:0]   plru_q  [SETS];
  logic [WAYS-1:0] hit_vec;
  logic [NB-1:0]   lk_next;
  logic [NB-1:0]   fill_next;

  assign req_ready  = !clr_busy;
  assign fill_ready = !clr_busy;
  assign hit_vec    = valid_q[req_set] & req_match;
  assign rsp_hit    = req_valid && req_ready && (|hit_vec);
  assign snp_hit    = !clr_busy && (|(valid_q[snp_set] & snp_match));

  always_comb begin
    rsp_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) rsp_way = WAY_W'(w);
    end
  end

  plru_update #(.WAYS(WAYS)) u_lk_upd (
    .cur_bits (plru_q[req_set]),
    .acc_way  (rsp_way),
    .next_bits(lk_next)
  );

  plru_update #(.WAYS(WAYS)) u_fill_upd (
    .cur_bits (plru_q[fill_set]),
    .acc_way  (fill_way),
    .next_bits(fill_next)
  );

  plru_victim #(.WAYS(WAYS)) u_fill_vic (
    .tree_bits(plru_q[fill_set]),
    .victim   (fill_victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        plru_q[s]  <= '0;
      end
    end else if (clr_busy) begin
      valid_q[clr_set] <= '0;
      plru_q[clr_set]  <= '0;
    end else begin
      if (rsp_hit) plru_q[req_set] <= lk_next;
      if (fill_valid) begin
        valid_q[fill_set][fill_way] <= 1'b1;
        plru_q[fill_set]            <= fill_next;
      end
    end
  end

  logic any_valid;
  logic any_plru;
  always_comb begin
    any_valid = 1'b0;
    any_plru  = 1'b0;
    for (int s = 0; s < SETS; s++) begin
      any_valid = any_valid | (|valid_q[s]);
      any_plru  = any_plru | (|plru_q[s]);
    end
  end

  assert_sweep_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_busy) |-> !any_valid);

  assert_sweep_plru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_busy) |-> !any_plru);

  assert_hit_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (valid_q[req_set][rsp_way] && req_match[rsp_way]));
endmodule

// File: rtl/flash_inval_top.sv
module flash_inval_top
  import flinv_pkg::*;
#(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic             ic_enable,
  input  logic             dc_enable,
  output logic [1:0]       cmd_pending,
  output logic [1:0]       busy,
  input  logic             i_req_valid,
  output logic             i_req_ready,
  input  logic [SET_W-1:0] i_req_set,
  input  logic [WAYS-1:0]  i_req_match,
  output logic             i_rsp_hit,
  output logic [WAY_W-1:0] i_rsp_way,
  input  logic             i_fill_valid,
  output logic             i_fill_ready,
  input  logic [SET_W-1:0] i_fill_set,
  input  logic [WAY_W-1:0] i_fill_way,
  output logic [WAY_W-1:0] i_fill_victim,
  input  logic [SET_W-1:0] i_snp_set,
  input  logic [WAYS-1:0]  i_snp_match,
  output logic             i_snp_hit,
  input  logic             d_req_valid,
  output logic             d_req_ready,
  input  logic [SET_W-1:0] d_req_set,
  input  logic [WAYS-1:0]  d_req_match,
  output logic             d_rsp_hit,
  output logic [WAY_W-1:0] d_rsp_way,
  input  logic             d_fill_valid,
  output logic             d_fill_ready,
  input  logic [SET_W-1:0] d_fill_set,
  input  logic [WAY_W-1:0] d_fill_way,
  output logic [WAY_W-1:0] d_fill_victim,
  input  logic [SET_W-1:0] d_snp_set,
  input  logic [WAYS-1:0]  d_snp_match,
  output logic             d_snp_hit
);
  logic [SET_W-1:0] i_clr_set;
  logic [SET_W-1:0] d_clr_set;

  flinv_seq #(.SETS(SETS)) u_seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .wr_bit (reg_wr_data[ICMD_BIT]),
    .enable (ic_enable),
    .cmd_q  (cmd_pending[CACHE_I]),
    .busy_q (busy[CACHE_I]),
    .set_idx(i_clr_set)
  );

  flinv_seq #(.SETS(SETS)) u_seq_d (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .wr_bit (reg_wr_data[DCMD_BIT]),
    .enable (dc_enable),
    .cmd_q  (cmd_pending[CACHE_D]),
    .busy_q (busy[CACHE_D]),
    .set_idx(d_clr_set)
  );

  cache_state_bank #(.SETS(SETS), .WAYS(WAYS)) u_bank_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_busy   (busy[CACHE_I]),
    .clr_set    (i_clr_set),
    .req_valid  (i_req_valid),
    .req_ready  (i_req_ready),
    .req_set    (i_req_set),
    .req_match  (i_req_match),
    .rsp_hit    (i_rsp_hit),
    .rsp_way    (i_rsp_way),
    .fill_valid (i_fill_valid),
    .fill_ready (i_fill_ready),
    .fill_set   (i_fill_set),
    .fill_way   (i_fill_way),
    .fill_victim(i_fill_victim),
    .snp_set    (i_snp_set),
    .snp_match  (i_snp_match),
    .snp_hit    (i_snp_hit)
  );

  cache_state_bank #(.SETS(SETS), .WAYS(WAYS)) u_bank_d (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_busy   (busy[CACHE_D]),
    .clr_set    (d_clr_set),
    .req_valid  (d_req_valid),
    .req_ready  (d_req_ready),
    .req_set    (d_req_set),
    .req_match  (d_req_match),
    .rsp_hit    (d_rsp_hit),
    .rsp_way    (d_rsp_way),
    .fill_valid (d_fill_valid),
    .fill_ready (d_fill_ready),
    .fill_set   (d_fill_set),
    .fill_way   (d_fill_way),
    .fill_victim(d_fill_victim),
    .snp_set    (d_snp_set),
    .snp_match  (d_snp_match),
    .snp_hit    (d_snp_hit)
  );
endmodule

// File: tb/sim_flash_inval_top.sv
module sim_flash_inval_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 64;
  localparam int WAYS = 4;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic ic_enable = 1'b1, dc_enable = 1'b1;
  logic [1:0] cmd_pending, busy;
  logic i_req_valid = 0, i_req_ready, i_rsp_hit, i_fill_valid = 0, i_fill_ready, i_snp_hit;
  logic d_req_valid = 0, d_req_ready, d_rsp_hit, d_fill_valid = 0, d_fill_ready, d_snp_hit;
  logic [SET_W-1:0] i_req_set = 0, i_fill_set = 0, i_snp_set = 0;
  logic [SET_W-1:0] d_req_set = 0, d_fill_set = 0, d_snp_set = 0;
  logic [WAYS-1:0] i_req_match = 0, i_snp_match = 0, d_req_match = 0, d_snp_match = 0;
  logic [WAY_W-1:0] i_rsp_way, i_fill_way = 0, i_fill_victim;
  logic [WAY_W-1:0] d_rsp_way, d_fill_way = 0, d_fill_victim;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_inval_top #(.SETS(SETS), .WAYS(WAYS)) u0 (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [31:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
    reg_wr_data = '0;
  endtask

  // Fill victim way of a set in cache c (1 = instruction); returns the way used.
  task automatic fill_victim(bit c, int set, output int way);
    @(negedge clk);
    if (c) begin
      i_fill_set = SET_W'(set);
      #1 way = int'(i_fill_victim);
      i_fill_way = WAY_W'(way); i_fill_valid = 1;
    end else begin
      d_fill_set = SET_W'(set);
      #1 way = int'(d_fill_victim);
      d_fill_way = WAY_W'(way); d_fill_valid = 1;
    end
    @(negedge clk);
    i_fill_valid = 0; d_fill_valid = 0;
  endtask

  task automatic peek_victim(bit c, int set, output int way);
    @(negedge clk);
    if (c) begin i_fill_set = SET_W'(set); #1 way = int'(i_fill_victim); end
    else begin d_fill_set = SET_W'(set); #1 way = int'(d_fill_victim); end
  endtask

  task automatic lookup(bit c, int set, logic [WAYS-1:0] m, output int hit, output int way, output int rdy);
    @(negedge clk);
    if (c) begin
      i_req_valid = 1; i_req_set = SET_W'(set); i_req_match = m;
      #1 hit = int'(i_rsp_hit); way = int'(i_rsp_way); rdy = int'(i_req_ready);
    end else begin
      d_req_valid = 1; d_req_set = SET_W'(set); d_req_match = m;
      #1 hit = int'(d_rsp_hit); way = int'(d_rsp_way); rdy = int'(d_req_ready);
    end
    @(negedge clk);
    i_req_valid = 0; d_req_valid = 0;
  endtask

  task automatic snoop(bit c, int set, logic [WAYS-1:0] m, output int hit);
    if (c) begin i_snp_set = SET_W'(set); i_snp_match = m; #1 hit = int'(i_snp_hit); end
    else begin d_snp_set = SET_W'(set); d_snp_match = m; #1 hit = int'(d_snp_hit); end
  endtask

  task automatic t_reset();
    int v;
    @(negedge clk);
    chk("R1", "cmd_pending after reset", int'(cmd_pending), 0);
    chk("R2", "busy after reset", int'(busy), 0);
    chk("R6", "i_req_ready idle", int'(i_req_ready), 1);
    peek_victim(1, 9, v);
    chk("R5", "reset victim", v, 0);
  endtask

  task automatic t_field();
    wr_ctrl(32'h0010_0000);
    chk("R1", "unrelated bit ignored", int'(cmd_pending), 0);
    chk("R1", "no busy from unrelated bit", int'(busy), 0);
  endtask

  task automatic t_fill_order();
    int w;
    int exp_seq [5] = '{0, 2, 1, 3, 0};
    for (int k = 0; k < 4; k++) begin
      fill_victim(1, 5, w);
      chk("R9", "fill victim order", w, exp_seq[k]);
    end
    peek_victim(1, 5, w);
    chk("R9", "victim after four fills", w, exp_seq[4]);
    fill_victim(1, 63, w);
  endtask

  task automatic t_lookup();
    int h, w, r;
    lookup(1, 5, 4'b0100, h, w, r);
    chk("R8", "hit valid matching way", h, 1);
    chk("R8", "hit way", w, 2);
    peek_victim(1, 5, w);
    chk("R9", "victim after hit way 2", w, 0);
    lookup(1, 5, 4'b0001, h, w, r);
    peek_victim(1, 5, w);
    chk("R9", "victim after hit way 0", w, 3);
    lookup(1, 6, 4'b0010, h, w, r);
    chk("R8", "match on invalid way misses", h, 0);
    lookup(1, 5, 4'b1010, h, w, r);
    chk("R8", "lowest matching way", w, 1);
    lookup(1, 5, 4'b0000, h, w, r);
    chk("R8", "no tag match misses", h, 0);
    @(negedge clk);
    snoop(1, 5, 4'b1000, h);
    chk("R8", "snoop hit idle", h, 1);
  endtask

  task automatic t_disabled();
    int h, w, r;
    ic_enable = 0;
    wr_ctrl(32'h0000_0800);
    chk("R3", "cmd held while disabled", int'(cmd_pending[1]), 1);
    repeat (3) @(negedge clk);
    chk("R3", "cmd still held", int'(cmd_pending[1]), 1);
    chk("R3", "no busy while disabled", int'(busy[1]), 0);
    lookup(1, 5, 4'b0100, h, w, r);
    chk("R3", "state kept while disabled", h, 1);
    ic_enable = 1;
    @(negedge clk);
    chk("R3", "cmd clears after enable", int'(cmd_pending[1]), 0);
    chk("R3", "busy after enable", int'(busy[1]), 1);
    while (busy[1]) @(negedge clk);
  endtask

  task automatic t_sweep();
    int h, w, r, len;
    fill_victim(1, 5, w);
    fill_victim(1, 63, w);
    wr_ctrl(32'h0000_0800);
    chk("R2", "cmd visible one cycle", int'(cmd_pending[1]), 1);
    @(negedge clk);
    chk("R2", "cmd auto-cleared", int'(cmd_pending[1]), 0);
    chk("R2", "busy started", int'(busy[1]), 1);
    snoop(1, 63, 4'b1111, h);
    chk("R7", "snoop miss during sweep", h, 0);
    chk("R6", "fill ready low during sweep", int'(i_fill_ready), 0);
    i_req_valid = 1; i_req_set = 63; i_req_match = 4'b1111;
    #1;
    chk("R6", "req ready low during sweep", int'(i_req_ready), 0);
    chk("R6", "no hit during sweep", int'(i_rsp_hit), 0);
    len = 0;
    while (busy[1] && len < 1000) begin
      len++;
      @(negedge clk);
      i_req_valid = 0;
    end
    chk("R2", "busy length", len, SETS);
    lookup(1, 5, 4'b1111, h, w, r);
    chk("R4", "set 5 invalid after sweep", h, 0);
    lookup(1, 63, 4'b1111, h, w, r);
    chk("R4", "set 63 invalid after sweep", h, 0);
    peek_victim(1, 5, w);
    chk("R5", "victim way 0 after sweep", w, 0);
  endtask

  task automatic t_concurrent();
    int h, w, r;
    fill_victim(1, 2, w);
    fill_victim(0, 2, w);
    wr_ctrl(32'h0000_0400);
    @(negedge clk);
    chk("R10", "data busy", int'(busy[0]), 1);
    chk("R10", "instr not busy", int'(busy[1]), 0);
    snoop(0, 2, 4'b1111, h);
    chk("R7", "data snoop miss during sweep", h, 0);
    lookup(1, 2, 4'b1111, h, w, r);
    chk("R10", "instr hit during data sweep", h, 1);
    while (busy[0]) @(negedge clk);
    fill_victim(1, 2, w);
    fill_victim(0, 2, w);
    wr_ctrl(32'h0000_0C00);
    @(negedge clk);
    chk("R10", "both busy together", int'(busy), 3);
    while (busy != 0) @(negedge clk);
    lookup(1, 2, 4'b1111, h, w, r);
    chk("R4", "instr invalid after joint sweep", h, 0);
    lookup(0, 2, 4'b1111, h, w, r);
    chk("R4", "data invalid after joint sweep", h, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_field();
    t_fill_order();
    t_lookup();
    t_disabled();
    t_sweep();
    t_concurrent();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule